// File: doc/BRIEF.md
# Timed Waveform Sequencer for an SPI DAC

This block plays a stored list of samples out to a digital-to-analog converter, one sample per SPI transfer. It fetches each sample from a synchronous memory read port and places it in a transmit register that the SPI master reads. It then starts the transfer through an arm / finished / ready handshake. Once the master reports it is ready again, the block waits a programmable number of cycles before it fetches the next sample. Software controls it through four plain inputs: a run bit, a loop enable, the sample count and the gap between samples. It can follow the current sample index, the gap timer and two status flags.

When looping is off, the block plays the list once and then reports that it is finished. The finished flag holds until run is dropped. When looping is on, the index wraps to zero after the last sample and playback continues until run is cleared. An SPI transfer that has started is never cut short. Clearing run lets the transfer in flight complete, then returns the block to idle with the index at zero.

Top module: `wave_seq_spi`

## Requirements
- R1: After reset, spi_arm_o, mem_rd_o and finished_o are low, index_o and timer_o are 0, and ready_o is high while run_i is low.
- R2: With run_i high and a nonzero length, samples are fetched in the order 0 to len-1. Each fetch is a one-cycle mem_rd_o pulse with mem_addr_o equal to index_o. mem_data_i is taken one cycle after the pulse and appears on spi_tx_o when spi_arm_o rises.
- R3: spi_arm_o stays high until spi_finished_i is seen, then drops. spi_tx_o does not change while spi_arm_o is high.
- R4: After arm drops, the block waits for spi_ready_i. Counting from the first cycle in which it sees spi_ready_i high, spi_arm_o rises again S+4 cycles later, where S is spacing_i.
- R5: During the gap, timer_o counts 0,1,…,S. It is 0 in idle and holds its last value otherwise.
- R6: Without looping, finished_o rises after the last transfer with index_o = len-1. It stays high with no further transfers while run_i stays high.
- R7: With loop_i high, the sample after index len-1 is index 0, and finished_o never rises.
- R8: Dropping run_i lets any transfer in flight complete. The block then returns to idle with index_o = 0, finished_o low and ready_o high. Dropping run_i during the gap returns to idle without another transfer.
- R9: A length of 0 makes finished_o rise with no fetch and no transfer.
- R10: ready_o is high only in idle with run_i low. It is never high together with finished_o or spi_arm_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Start / keep streaming |
| loop_i | input | 1 | Wrap to sample 0 after the last sample |
| wave_len_i | input | CNT_W | Number of samples |
| spacing_i | input | TMR_W | Gap parameter S between transfers |
| mem_rd_o | output | 1 | Read strobe to the sample memory |
| mem_addr_o | output | CNT_W | Sample memory address |
| mem_data_i | input | DATA_W | Sample read data, valid one cycle after the strobe |
| spi_tx_o | output | DATA_W | Word for the SPI master to transmit |
| spi_arm_o | output | 1 | Starts and holds an SPI transfer |
| spi_ready_i | input | 1 | SPI master idle and ready to be armed |
| spi_finished_i | input | 1 | SPI master done with the armed transfer |
| index_o | output | CNT_W | Current sample index |
| timer_o | output | TMR_W | Current gap timer value |
| ready_o | output | 1 | Idle with run low |
| finished_o | output | 1 | Non-looping pass complete |

## Verification
The bench builds the block with its default parameters: DATA_W=24, CNT_W=16, TMR_W=16 and a two-stage reset synchronizer. Sample lengths from 0 to 5 and spacings from 0 to 20 keep every transfer, wrap and gap short. With those short runs, the exact arm-to-arm cycle count, the order of fetched words and every status edge can be checked against a small SPI model whose transfer takes four armed cycles.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_LOAD   = 3'd2,
    ST_ARM    = 3'd3,
    ST_DISARM = 3'd4,
    ST_SPACE  = 3'd5,
    ST_DONE   = 3'd6
  } wseq_state_e;
endpackage

// File: rtl/wseq_rst_sync.sv
module wseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= 1'b1;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wseq_index_ctr.sv
module wseq_index_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             last_o,
  output logic             len_zero_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] idx_q, idx_d;
  logic [EXT_W-1:0] idx_next_ext;

  assign idx_next_ext = {1'b0, idx_q} + EXT_W'(1);
  assign last_o       = idx_next_ext >= {1'b0, len_i};
  assign len_zero_o   = (len_i == '0);

  always_comb begin
    idx_d = idx_q;
    if (clr_i)      idx_d = '0;
    else if (inc_i) idx_d = idx_next_ext[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              idx_q <= '0;
    else if (clr_i || inc_i) idx_q <= idx_d;
  end

  assign idx_o = idx_q;

  // R2: the controller never steps past the final sample
  a_r2_no_step_past_last: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |-> !last_o);
endmodule

// File: rtl/wseq_gap_timer.sv
module wseq_gap_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [TMR_W-1:0] spacing_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic             done_o
);
  logic [TMR_W-1:0] tmr_q, tmr_d;

  assign done_o = tmr_q >= spacing_i;

  always_comb begin
    tmr_d = tmr_q;
    if (clr_i)      tmr_d = '0;
    else if (inc_i) tmr_d = tmr_q + TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              tmr_q <= '0;
    else if (clr_i || inc_i) tmr_q <= tmr_d;
  end

  assign tmr_o = tmr_q;

  // R5: counting only happens below the programmed gap, so the timer cannot wrap
  a_r5_timer_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |-> (tmr_o < spacing_i));
endmodule

// File: rtl/wseq_sample_reg.sv
module wseq_sample_reg #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] tx_o
);
  logic [DATA_W-1:0] tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tx_q <= '0;
    else if (load_i) tx_q <= data_i;
  end

  assign tx_o = tx_q;
endmodule

// File: rtl/wseq_ctrl_fsm.sv
module wseq_ctrl_fsm
  import wseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic loop_i,
  input  logic spi_ready_i,
  input  logic spi_finished_i,
  input  logic len_zero_i,
  input  logic idx_last_i,
  input  logic tmr_done_i,
  output logic idx_clr_o,
  output logic idx_inc_o,
  output logic tmr_clr_o,
  output logic tmr_inc_o,
  output logic mem_rd_o,
  output logic tx_load_o,
  output logic spi_arm_o,
  output logic ready_o,
  output logic finished_o
);
  wseq_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    idx_clr_o = 1'b0;
    idx_inc_o = 1'b0;
    tmr_clr_o = 1'b0;
    tmr_inc_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        tmr_clr_o = 1'b1;
        if (run_i) state_d = len_zero_i ? ST_DONE : ST_READ;
      end
      ST_READ:   state_d = ST_LOAD;
      ST_LOAD:   state_d = ST_ARM;
      ST_ARM:    if (spi_finished_i) state_d = ST_DISARM;
      ST_DISARM: begin
        if (spi_ready_i) begin
          if (!run_i) begin
            state_d   = ST_IDLE;
            idx_clr_o = 1'b1;
          end else if (idx_last_i && !loop_i) begin
            state_d = ST_DONE;
          end else begin
            state_d   = ST_SPACE;
            tmr_clr_o = 1'b1;
            idx_clr_o = idx_last_i;
            idx_inc_o = !idx_last_i;
          end
        end
      end
      ST_SPACE: begin
        if (!run_i) begin
          state_d   = ST_IDLE;
          idx_clr_o = 1'b1;
        end else if (tmr_done_i) begin
          state_d = ST_READ;
        end else begin
          tmr_inc_o = 1'b1;
        end
      end
      ST_DONE: begin
        if (!run_i) begin
          state_d   = ST_IDLE;
          idx_clr_o = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign mem_rd_o   = (state_q == ST_READ);
  assign tx_load_o  = (state_q == ST_LOAD);
  assign spi_arm_o  = (state_q == ST_ARM);
  assign finished_o = (state_q == ST_DONE);
  assign ready_o    = (state_q == ST_IDLE) && !run_i;

  // R3: a transfer is never abandoned before the master reports completion
  a_r3_arm_held: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_arm_o && !spi_finished_i) |=> spi_arm_o);
  // R2: each fetch is a single-cycle strobe
  a_r2_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> !mem_rd_o);
  // R6: completion holds while run stays high
  a_r6_finished_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (finished_o && run_i) |=> finished_o);
  // R10: ready excludes finished and an armed transfer
  a_r10_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (!finished_o && !spi_arm_o));
  // R7: a looping pass never reports completion
  a_r7_loop_no_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_i && $past(loop_i) && !$past(finished_o)) |-> !$rose(finished_o));
endmodule

// File: rtl/wave_seq_spi.sv
module wave_seq_spi #(
  parameter int DATA_W      = 24,
  parameter int CNT_W       = 16,
  parameter int TMR_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              loop_i,
  input  logic [CNT_W-1:0]  wave_len_i,
  input  logic [TMR_W-1:0]  spacing_i,
  output logic              mem_rd_o,
  output logic [CNT_W-1:0]  mem_addr_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [DATA_W-1:0] spi_tx_o,
  output logic              spi_arm_o,
  input  logic              spi_ready_i,
  input  logic              spi_finished_i,
  output logic [CNT_W-1:0]  index_o,
  output logic [TMR_W-1:0]  timer_o,
  output logic              ready_o,
  output logic              finished_o
);
  logic srst_n;
  logic idx_clr, idx_inc, idx_last, len_zero;
  logic tmr_clr, tmr_inc, tmr_done;
  logic tx_load;

  wseq_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(srst_n)
  );

  wseq_ctrl_fsm ctrl_i (
    .clk(clk), .rst_n(srst_n),
    .run_i(run_i), .loop_i(loop_i),
    .spi_ready_i(spi_ready_i), .spi_finished_i(spi_finished_i),
    .len_zero_i(len_zero), .idx_last_i(idx_last), .tmr_done_i(tmr_done),
    .idx_clr_o(idx_clr), .idx_inc_o(idx_inc),
    .tmr_clr_o(tmr_clr), .tmr_inc_o(tmr_inc),
    .mem_rd_o(mem_rd_o), .tx_load_o(tx_load), .spi_arm_o(spi_arm_o),
    .ready_o(ready_o), .finished_o(finished_o)
  );

  wseq_index_ctr #(.CNT_W(CNT_W)) idx_i (
    .clk(clk), .rst_n(srst_n), .clr_i(idx_clr), .inc_i(idx_inc),
    .len_i(wave_len_i), .idx_o(index_o), .last_o(idx_last), .len_zero_o(len_zero)
  );

  wseq_gap_timer #(.TMR_W(TMR_W)) tmr_i (
    .clk(clk), .rst_n(srst_n), .clr_i(tmr_clr), .inc_i(tmr_inc),
    .spacing_i(spacing_i), .tmr_o(timer_o), .done_o(tmr_done)
  );

  wseq_sample_reg #(.DATA_W(DATA_W)) txreg_i (
    .clk(clk), .rst_n(srst_n), .load_i(tx_load),
    .data_i(mem_data_i), .tx_o(spi_tx_o)
  );

  assign mem_addr_o = index_o;

  // R3: the transmitted word is frozen for the whole armed interval
  a_r3_tx_stable: assert property (@(posedge clk) disable iff (!srst_n)
    (spi_arm_o && $past(spi_arm_o)) |-> $stable(spi_tx_o));
  // R9: a zero length never produces a fetch
  a_r9_zero_len_no_read: assert property (@(posedge clk) disable iff (!srst_n)
    mem_rd_o |-> (mem_addr_o < wave_len_i));
endmodule

// File: tb/wave_seq_spi_tb_top.sv
module wave_seq_spi_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XFER_CYC   = 3;

  typedef struct packed {
    logic [15:0] len;
    logic [15:0] sp;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{len: 16'd1, sp: 16'd0},
    '{len: 16'd3, sp: 16'd2},
    '{len: 16'd4, sp: 16'd0},
    '{len: 16'd2, sp: 16'd7},
    '{len: 16'd5, sp: 16'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run, loop_en;
  logic [15:0] len, spacing;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [23:0] mem_q;
  logic [23:0] tx;
  logic        arm, spi_ready, spi_fin;
  logic [15:0] index, timer;
  logic        ready, finished;

  int checks = 0;
  int failures = 0;
  int xfer_cnt, gap, max_tmr, exp_sp, exp_mod;
  bit gap_active, arm_prev, fin_seen;
  int spi_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_seq_spi dut_i (
    .clk(clk), .rst_n(rst_n), .run_i(run), .loop_i(loop_en),
    .wave_len_i(len), .spacing_i(spacing),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_q),
    .spi_tx_o(tx), .spi_arm_o(arm),
    .spi_ready_i(spi_ready), .spi_finished_i(spi_fin),
    .index_o(index), .timer_o(timer), .ready_o(ready), .finished_o(finished)
  );

  function automatic logic [23:0] fval(int i);
    return 24'hA50000 ^ 24'((i * 13 + 7) & 16'hFFFF);
  endfunction

  // Synchronous sample memory, data one cycle after the strobe
  always @(posedge clk) if (mem_rd) mem_q <= fval(int'(mem_addr));

  // SPI master model: finished after XFER_CYC armed cycles, ready one cycle after arm drops
  always @(posedge clk) begin
    if (!arm) begin
      spi_fin <= 1'b0;
      spi_cnt <= 0;
    end else if (!spi_fin) begin
      if (spi_cnt == XFER_CYC - 1) spi_fin <= 1'b1;
      else spi_cnt <= spi_cnt + 1;
    end
  end
  assign spi_ready = !arm && !spi_fin;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor away from the active edge
  always @(negedge clk) begin
    if (run && int'(timer) > max_tmr) max_tmr = int'(timer);
    if (finished) fin_seen = 1'b1;
    if (arm && !arm_prev) begin
      if (gap_active) check(gap == exp_sp + 5, "R4 arm-to-arm gap", gap, exp_sp + 5);
      check(tx == fval(xfer_cnt % exp_mod), "R2 sample word on arm rise",
            int'(tx), int'(fval(xfer_cnt % exp_mod)));
      xfer_cnt++;
      gap_active = 1'b0;
    end else if (!arm && arm_prev) begin
      gap = 1;
      gap_active = 1'b1;
    end else if (!arm && gap_active) begin
      gap++;
    end
    arm_prev = arm;
  end

  task automatic arm_test(input int l, input int s, input bit lp);
    @(negedge clk);
    len = 16'(l); spacing = 16'(s); loop_en = lp;
    xfer_cnt = 0; gap_active = 1'b0; max_tmr = 0; fin_seen = 1'b0;
    exp_sp = s; exp_mod = (l == 0) ? 1 : l;
    run = 1'b1;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic stop_and_idle(input string req);
    @(negedge clk);
    run = 1'b0;
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(ready == 1'b1, req, int'(ready), 1);
    check(index == 16'd0, req, int'(index), 0);
    check(finished == 1'b0, req, int'(finished), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; loop_en = 1'b0; len = '0; spacing = '0;
    exp_sp = 0; exp_mod = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(arm == 1'b0, "R1 arm low", int'(arm), 0);
    check(mem_rd == 1'b0, "R1 read strobe low", int'(mem_rd), 0);
    check(finished == 1'b0, "R1 finished low", int'(finished), 0);
    check(index == 16'd0, "R1 index zero", int'(index), 0);
    check(timer == 16'd0, "R1 timer zero", int'(timer), 0);
    check(ready == 1'b1, "R1 R10 ready in idle", int'(ready), 1);

    // Vector walk: single non-looping passes
    for (int v = 0; v < 5; v++) begin
      arm_test(int'(VECS[v].len), int'(VECS[v].sp), 1'b0);
      for (int k = 0; k < 2000 && !finished; k++) @(posedge clk);
      wait_cycles(10);
      @(negedge clk);
      check(finished == 1'b1, "R6 finished after pass", int'(finished), 1);
      check(xfer_cnt == int'(VECS[v].len), "R2 R6 transfer count", xfer_cnt, int'(VECS[v].len));
      check(int'(index) == int'(VECS[v].len) - 1, "R6 index at last", int'(index), int'(VECS[v].len) - 1);
      check(ready == 1'b0, "R10 no ready while finished", int'(ready), 0);
      check(max_tmr == ((VECS[v].len > 1) ? int'(VECS[v].sp) : 0), "R5 timer peak",
            max_tmr, (VECS[v].len > 1) ? int'(VECS[v].sp) : 0);
      stop_and_idle("R8 idle after finished pass");
    end

    // R9 zero length
    arm_test(0, 3, 1'b0);
    wait_cycles(10);
    @(negedge clk);
    check(finished == 1'b1, "R9 zero length finished", int'(finished), 1);
    check(xfer_cnt == 0, "R9 zero length no transfer", xfer_cnt, 0);
    stop_and_idle("R9 idle after zero length");

    // R7 looping, then R8 clear run while armed
    arm_test(3, 1, 1'b1);
    for (int k = 0; k < 3000 && xfer_cnt < 5; k++) @(posedge clk);
    check(arm == 1'b1, "R8 stop requested while armed", int'(arm), 1);
    stop_and_idle("R8 idle after in-flight transfer");
    check(xfer_cnt == 5, "R7 R8 wrap count and transfer completes", xfer_cnt, 5);
    check(fin_seen == 1'b0, "R7 no finished while looping", int'(fin_seen), 0);

    // R8 clear run during the gap
    arm_test(4, 20, 1'b0);
    for (int k = 0; k < 2000 && xfer_cnt < 1; k++) @(posedge clk);
    for (int k = 0; k < 2000 && arm; k++) @(posedge clk);
    wait_cycles(6);
    @(negedge clk);
    check(int'(timer) > 0, "R5 timer counting in gap", int'(timer), 1);
    stop_and_idle("R8 idle after stop in gap");
    check(xfer_cnt == 1, "R8 no transfer after stop in gap", xfer_cnt, 1);
    check(timer == 16'd0, "R5 timer zero in idle", int'(timer), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule